// File: doc/BRIEF.md
# Fused macro-op integer ALU

This block is a 64-bit integer execution unit. It evaluates the internal opcodes that a front-end decoder issues when it merges two adjacent integer instructions into one operation. Each opcode gives the result that the two-instruction idiom would have left in its destination register. The covered idioms are:

- shift-then-extract and shift-then-add
- parity add
- word add followed by a bit, byte or halfword extract
- a logic operation followed by a mask
- a masked OR

The caller presents two 64-bit sources, a 5-bit opcode and a valid strobe. For immediate forms, the caller passes the sign-extended immediate as the second source. One register stage later the unit returns the 64-bit result with an output valid. An opcode outside the legal set returns zero and raises a flag on that output.

Top module: `fused_alu`

## Requirements
- R1: Opcodes 0x01, 0x02 and 0x03 take k = op[1:0] and return the low 32 bits of src1, zero-extended to 64 bits and then shifted left by k.
- R2: Opcode 0x04 returns src1 bits 15:8, zero-extended to 64 bits.
- R3: Opcode 0x05 returns (src1 << 4) + src2, modulo 2^64.
- R4: Opcodes 0x08 to 0x0B take N = 29 + op[1:0] and return (src1 logically shifted right by N) + src2, modulo 2^64.
- R5: Opcode 0x0C returns (src1 & 1) + src2 modulo 2^64. Opcode 0x0D forms the same sum on the low 32 bits and sign-extends bit 31 of that sum to 64 bits.
- R6: Opcode 0x0E returns {src1[63:8], 8'h00} | src2.
- R7: Let the 32-bit wrapping sum be src1[31:0] + src2[31:0]. Opcode 0x10 returns the sum's low 8 bits, zero-extended. Opcode 0x11 returns only bit 0 of the sum.
- R8: On the same 32-bit sum, opcode 0x12 returns the low 16 bits zero-extended and opcode 0x13 returns the low 16 bits sign-extended.
- R9: Opcodes 0x14 to 0x17 apply a logic operation to src1 and src2 and return only bit 0. The operation is selected by op[1:0]: 0 is AND, 1 is OR, 2 is XOR, 3 is OR-combine of src1 alone (each byte becomes 0xFF if any of its bits is set, else 0x00).
- R10: Opcodes 0x18 to 0x1B apply the same op[1:0] logic selection and return bits 15:0, zero-extended.
- R11: valid_o equals valid_i of the previous clock. result_o loads only in a cycle where valid_i is high and otherwise holds its value. Reset clears valid_o, result_o and illegal_o.
- R12: Opcodes 0x00, 0x06, 0x07, 0x0F and 0x1C to 0x1F are illegal. An accepted illegal opcode yields result_o = 0 and raises illegal_o for exactly the cycle in which valid_o reports it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 5 | Fused opcode |
| src1_i | input | 64 | First source operand |
| src2_i | input | 64 | Second source operand or sign-extended immediate |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 64 | Registered result |
| illegal_o | output | 1 | Unrecognized opcode reported with this result |

## Verification
The bench pushes carries across bit 31 in the word-add opcodes. A design that summed in 64 bits would leak bit 32 or sign-extend from the wrong position. It also sets bit 15 of the word sum to expose a zero-extend/sign-extend swap, and it uses all-ones second operands to force wrap-around in the shift-add opcodes. It feeds OR-combine zero bytes next to non-zero ones, which catches a byte mask taken from the wrong source. It also drops valid in random cycles and sends every illegal code, so a result register that loads without valid, or an illegal opcode that leaks data or leaves the flag set for a second cycle, is reported against a behavioural reference.

// File: rtl/fal_pkg.sv
package fal_pkg;
  localparam int unsigned OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ZWS1        = 5'h01,
    OP_ZWS2        = 5'h02,
    OP_ZWS3        = 5'h03,
    OP_BYTE1       = 5'h04,
    OP_SHL4ADD     = 5'h05,
    OP_SRADD29     = 5'h08,
    OP_SRADD30     = 5'h09,
    OP_SRADD31     = 5'h0A,
    OP_SRADD32     = 5'h0B,
    OP_ODDADD      = 5'h0C,
    OP_ODDADDW     = 5'h0D,
    OP_MASKOR      = 5'h0E,
    OP_WADD_BYTE   = 5'h10,
    OP_WADD_BIT    = 5'h11,
    OP_WADD_ZEXTH  = 5'h12,
    OP_WADD_SEXTH  = 5'h13,
    OP_LOGIC_LSB   = 5'h14,
    OP_LOGIC_ZEXTH = 5'h18
  } fal_op_e;

  // op[4:2] groups for the logic family; op[1:0] picks the operation
  localparam logic [2:0] GRP_LOGIC_LSB   = 3'b101;
  localparam logic [2:0] GRP_LOGIC_ZEXTH = 3'b110;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2,
    LG_ORC = 2'd3
  } fal_logic_e;
endpackage

// File: rtl/fal_shadd_unit.sv
module fal_shadd_unit
  import fal_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [XLEN-1:0] src1_i,
  input  logic [XLEN-1:0] src2_i,
  output logic            hit_o,
  output logic [XLEN-1:0] res_o
);
  localparam int unsigned WORD = 32;
  localparam int unsigned SR_BASE = 29;

  logic [XLEN-1:0] zext_word;
  logic [5:0]      sr_amt;
  logic [WORD-1:0] odd_word;

  assign zext_word = {{(XLEN-WORD){1'b0}}, src1_i[WORD-1:0]};
  assign sr_amt    = 6'(SR_BASE) + {4'b0, op_i[1:0]};
  assign odd_word  = src2_i[WORD-1:0] + {{(WORD-1){1'b0}}, src1_i[0]};

  always_comb begin
    hit_o = 1'b1;
    res_o = '0;
    case (op_i)
      OP_ZWS1, OP_ZWS2, OP_ZWS3:
        res_o = zext_word << op_i[1:0];
      OP_BYTE1:
        res_o = {{(XLEN-8){1'b0}}, src1_i[15:8]};
      OP_SHL4ADD:
        res_o = (src1_i << 4) + src2_i;
      OP_SRADD29, OP_SRADD30, OP_SRADD31, OP_SRADD32:
        res_o = (src1_i >> sr_amt) + src2_i;
      OP_ODDADD:
        res_o = {{(XLEN-1){1'b0}}, src1_i[0]} + src2_i;
      OP_ODDADDW:
        res_o = {{(XLEN-WORD){odd_word[WORD-1]}}, odd_word};
      OP_MASKOR:
        res_o = {src1_i[XLEN-1:8], 8'h00} | src2_i;
      default:
        hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fal_wadd_unit.sv
module fal_wadd_unit
  import fal_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned WORD = 32
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [WORD-1:0] a_i,
  input  logic [WORD-1:0] b_i,
  output logic            hit_o,
  output logic [XLEN-1:0] res_o
);
  localparam int unsigned HALF = 16;

  logic [WORD-1:0] sum;
  assign sum = a_i + b_i;

  always_comb begin
    hit_o = 1'b1;
    res_o = '0;
    case (op_i)
      OP_WADD_BYTE:  res_o = {{(XLEN-8){1'b0}}, sum[7:0]};
      OP_WADD_BIT:   res_o = {{(XLEN-1){1'b0}}, sum[0]};
      OP_WADD_ZEXTH: res_o = {{(XLEN-HALF){1'b0}}, sum[HALF-1:0]};
      OP_WADD_SEXTH: res_o = {{(XLEN-HALF){sum[HALF-1]}}, sum[HALF-1:0]};
      default:       hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fal_logic_unit.sv
module fal_logic_unit
  import fal_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [XLEN-1:0] src1_i,
  input  logic [XLEN-1:0] src2_i,
  output logic            hit_o,
  output logic [XLEN-1:0] res_o
);
  localparam int unsigned NBYTES = XLEN / 8;
  localparam int unsigned HALF   = 16;

  logic [XLEN-1:0] orc;
  logic [XLEN-1:0] lg;
  logic            is_lsb, is_zh;

  for (genvar b = 0; b < NBYTES; b++) begin : g_orc
    assign orc[b*8 +: 8] = {8{|src1_i[b*8 +: 8]}};
  end

  always_comb begin
    case (fal_logic_e'(op_i[1:0]))
      LG_AND:  lg = src1_i & src2_i;
      LG_OR:   lg = src1_i | src2_i;
      LG_XOR:  lg = src1_i ^ src2_i;
      default: lg = orc;
    endcase
  end

  assign is_lsb = (op_i[4:2] == GRP_LOGIC_LSB);
  assign is_zh  = (op_i[4:2] == GRP_LOGIC_ZEXTH);
  assign hit_o  = is_lsb | is_zh;

  always_comb begin
    res_o = '0;
    if (is_lsb) res_o[0] = lg[0];
    if (is_zh)  res_o[HALF-1:0] = lg[HALF-1:0];
  end
endmodule

// File: rtl/fused_alu.sv
module fused_alu
  import fal_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [XLEN-1:0] src1_i,
  input  logic [XLEN-1:0] src2_i,
  output logic            valid_o,
  output logic [XLEN-1:0] result_o,
  output logic            illegal_o
);
  localparam int unsigned WORD  = 32;
  localparam int unsigned NUNIT = 3;

  logic [NUNIT-1:0]           hit;
  logic [NUNIT-1:0][XLEN-1:0] part;
  logic [XLEN-1:0]            merged;
  logic                       illegal;

  fal_shadd_unit #(.XLEN(XLEN)) u_shadd (
    .op_i  (op_i),
    .src1_i(src1_i),
    .src2_i(src2_i),
    .hit_o (hit[0]),
    .res_o (part[0])
  );

  fal_wadd_unit #(.XLEN(XLEN), .WORD(WORD)) u_wadd (
    .op_i (op_i),
    .a_i  (src1_i[WORD-1:0]),
    .b_i  (src2_i[WORD-1:0]),
    .hit_o(hit[1]),
    .res_o(part[1])
  );

  fal_logic_unit #(.XLEN(XLEN)) u_logic (
    .op_i  (op_i),
    .src1_i(src1_i),
    .src2_i(src2_i),
    .hit_o (hit[2]),
    .res_o (part[2])
  );

  // units drive zero when not selected, so an OR merges them
  always_comb begin
    merged = '0;
    for (int u = 0; u < NUNIT; u++) merged = merged | part[u];
  end

  assign illegal = ~|hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      result_o  <= '0;
    end else begin
      valid_o   <= valid_i;
      illegal_o <= valid_i & illegal;
      if (valid_i) result_o <= illegal ? '0 : merged;
    end
  end
endmodule

// File: rtl/fal_checker.sv
module fal_checker
  import fal_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [OP_W-1:0] op_i,
  input logic            valid_o,
  input logic [XLEN-1:0] result_o,
  input logic            illegal_o
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R11
  AST_VALID_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R11
  AST_RESULT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)); // R11
  AST_ILLEGAL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (valid_o && result_o == '0)); // R12
  AST_WADD_BYTE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_WADD_BYTE) |=> (result_o[XLEN-1:8] == '0)); // R7
  AST_WADD_BIT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_WADD_BIT) |=> (result_o[XLEN-1:1] == '0)); // R7
  AST_WADD_SEXT_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_WADD_SEXTH) |=> (result_o[XLEN-1:16] == {(XLEN-16){result_o[15]}})); // R8
  AST_LOGIC_LSB_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[4:2] == GRP_LOGIC_LSB) |=> (result_o[XLEN-1:1] == '0)); // R9
  AST_LEGAL_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == OP_MASKOR) |=> !illegal_o); // R12
endmodule

bind fused_alu fal_checker #(.XLEN(XLEN)) u_fal_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .op_i     (op_i),
  .valid_o  (valid_o),
  .result_o (result_o),
  .illegal_o(illegal_o)
);

// File: tb/fused_alu_tb_top.sv
`timescale 1ns/1ps
module fused_alu_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [4:0]  op_i = '0;
  logic [63:0] src1_i = '0;
  logic [63:0] src2_i = '0;
  logic        valid_o;
  logic [63:0] result_o;
  logic        illegal_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  logic        exp_valid = 1'b0;
  logic [63:0] exp_result = '0;
  logic        exp_illegal = 1'b0;
  string       exp_tag = "R11";

  always #2 clk_i = ~clk_i;

  fused_alu dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .src1_i(src1_i), .src2_i(src2_i), .valid_o(valid_o),
    .result_o(result_o), .illegal_o(illegal_o)
  );

  function automatic string tag_of(input logic [4:0] op);
    case (op)
      5'h01, 5'h02, 5'h03:                return "R1";
      5'h04:                              return "R2";
      5'h05:                              return "R3";
      5'h08, 5'h09, 5'h0A, 5'h0B:         return "R4";
      5'h0C, 5'h0D:                       return "R5";
      5'h0E:                              return "R6";
      5'h10, 5'h11:                       return "R7";
      5'h12, 5'h13:                       return "R8";
      5'h14, 5'h15, 5'h16, 5'h17:         return "R9";
      5'h18, 5'h19, 5'h1A, 5'h1B:         return "R10";
      default:                            return "R12";
    endcase
  endfunction

  function automatic logic [63:0] logic_op(input int sel, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r;
    r = '0;
    if (sel == 0) r = a & b;
    else if (sel == 1) r = a | b;
    else if (sel == 2) r = a ^ b;
    else for (int i = 0; i < 8; i++) if (a[i*8 +: 8] != 8'h00) r[i*8 +: 8] = 8'hFF;
    return r;
  endfunction

  // returns {illegal, result}
  function automatic logic [64:0] ref_model(input logic [4:0] op, input logic [63:0] a, input logic [63:0] b);
    logic [31:0] w;
    logic [63:0] t;
    int code;
    code = int'(op);
    w = a[31:0] + b[31:0];
    if (code >= 1 && code <= 3) return {1'b0, (64'(a[31:0])) << code};
    if (code == 4) return {1'b0, 64'((a >> 8) & 64'hFF)};
    if (code == 5) return {1'b0, a * 64'd16 + b};
    if (code >= 8 && code <= 11) return {1'b0, (a >> (code + 21)) + b};
    if (code == 12) return {1'b0, 64'(a % 2) + b};
    if (code == 13) begin
      t = 64'(a % 2) + b;
      return {1'b0, {{32{t[31]}}, t[31:0]}};
    end
    if (code == 14) return {1'b0, (a & ~64'hFF) | b};
    if (code == 16) return {1'b0, 64'(w % 256)};
    if (code == 17) return {1'b0, 64'(w % 2)};
    if (code == 18) return {1'b0, 64'(w % 65536)};
    if (code == 19) return {1'b0, {{48{w[15]}}, w[15:0]}};
    if (code >= 20 && code <= 23) return {1'b0, 64'(logic_op(code - 20, a, b) % 2)};
    if (code >= 24 && code <= 27) return {1'b0, 64'(logic_op(code - 24, a, b) % 65536)};
    return {1'b1, 64'h0};
  endfunction

  task automatic check_outputs();
    checks++;
    if (valid_o !== exp_valid) begin
      errors++;
      $display("FAIL R11 valid_o actual=%0b expected=%0b", valid_o, exp_valid);
    end
    checks++;
    if (result_o !== exp_result) begin
      errors++;
      $display("FAIL %s result_o actual=%h expected=%h", exp_tag, result_o, exp_result);
    end
    checks++;
    if (illegal_o !== exp_illegal) begin
      errors++;
      $display("FAIL R12 illegal_o actual=%0b expected=%0b", illegal_o, exp_illegal);
    end
  endtask

  // check previous cycle's outcome, then drive one new cycle
  task automatic step(input logic v, input logic [4:0] op, input logic [63:0] a, input logic [63:0] b);
    logic [64:0] m;
    @(negedge clk_i);
    check_outputs();
    valid_i = v; op_i = op; src1_i = a; src2_i = b;
    m = ref_model(op, a, b);
    exp_valid = v;
    exp_illegal = v & m[64];
    if (v) begin
      exp_result = m[63:0];
      exp_tag = tag_of(op);
    end else begin
      exp_tag = "R11";
    end
  endtask

  function automatic logic [63:0] pick_val();
    case ($urandom_range(0, 5))
      0: return 64'hFFFF_FFFF_FFFF_FFFF;
      1: return 64'h0000_0000_FFFF_FFFF;
      2: return 64'h0000_0000_0000_8000;
      3: return {$urandom, $urandom} & 64'hFF00_FF00_00FF_0000;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<=20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R11: reset state
    check_outputs();
    rst_ni = 1'b1;

    // R1: zero-extended word shift, upper bits of src1 dropped
    step(1, 5'h01, 64'hDEAD_BEEF_8000_0001, 64'h0);
    step(1, 5'h02, 64'hFFFF_FFFF_FFFF_FFFF, 64'h5);
    step(1, 5'h03, 64'h1234_5678_F000_000F, 64'h0);
    // R2
    step(1, 5'h04, 64'hFFFF_FFFF_FFFF_A5FF, 64'h0);
    // R3: wrap-around
    step(1, 5'h05, 64'hF000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFF0);
    // R4: each shift amount
    for (int k = 0; k < 4; k++)
      step(1, 5'(8 + k), 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    // R5: odd add, word form sign extension
    step(1, 5'h0C, 64'h3, 64'hFFFF_FFFF_FFFF_FFFF);
    step(1, 5'h0D, 64'h1, 64'h0000_0000_7FFF_FFFF);
    step(1, 5'h0D, 64'h2, 64'hFFFF_FFFF_0000_0010);
    // R6
    step(1, 5'h0E, 64'h1234_5678_9ABC_DEFF, 64'h0000_0000_0000_0011);
    // R7: carry across bit 31 must vanish
    step(1, 5'h10, 64'h0000_0000_FFFF_FFFF, 64'h1);
    step(1, 5'h11, 64'h0000_0001_0000_0002, 64'h1);
    // R8: bit 15 set
    step(1, 5'h12, 64'h0000_0000_0000_7FFF, 64'h1);
    step(1, 5'h13, 64'h0000_0000_0000_7FFF, 64'h1);
    step(1, 5'h13, 64'h0000_0000_0001_7FFE, 64'h1);
    // R9 / R10: every logic selector, OR-combine with zero bytes
    for (int s = 0; s < 4; s++) begin
      step(1, 5'(20 + s), 64'h0000_0100_0000_0001, 64'h0000_0000_0000_0003);
      step(1, 5'(24 + s), 64'h0000_0000_0100_8000, 64'h0000_0000_00FF_F0F0);
    end
    // R11: result holds while valid is low
    step(0, 5'h05, 64'h1, 64'h1);
    step(0, 5'h00, 64'hFFFF, 64'hFFFF);
    // R12: every illegal code, back to back and then a legal one
    step(1, 5'h00, 64'hFFFF, 64'h1);
    step(1, 5'h06, 64'hFFFF, 64'h1);
    step(1, 5'h07, 64'hFFFF, 64'h1);
    step(1, 5'h0F, 64'hFFFF, 64'h1);
    for (int c = 28; c < 32; c++) step(1, 5'(c), 64'hFFFF, 64'h1);
    step(1, 5'h0E, 64'hFF, 64'h1);

    // random sweep over all codes with valid gaps
    for (int n = 0; n < 4000; n++)
      step(($urandom_range(0, 3) != 0), 5'($urandom_range(0, 31)), pick_val(), pick_val());

    step(0, 5'h00, 64'h0, 64'h0);
    @(negedge clk_i);
    check_outputs();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule